// File: doc/BRIEF.md
# Tree Carry-Lookahead Adder

A purely combinational binary adder of parameterised width. Two unsigned operands and a carry-in go in. The sum and a carry-out come out in the same time step, with no clock and no state.

Each bit position first derives a generate term and a propagate term from its two operand bits. A balanced binary tree of identical two-input lookahead cells then works in two directions. On the way up it merges neighbouring pairs into group generate and propagate terms. On the way down it hands each subtree its incoming carry. Each sum bit is its propagate term XORed with the carry delivered to that bit position. The carry-out comes from the root's group terms and the external carry-in.

The width must be a power of two, at least 2, so that every level of the tree pairs up exactly. The default width is 8.

Top module: `treeCarryAdder`

## Requirements
- R1: For every bit i, the generate term is opA[i] AND opB[i] and the propagate term is opA[i] XOR opB[i]. As a result, the two terms are never both 1 at the same bit.
- R2: The carry into bit 0 is carryIn, so sum[0] equals opA[0] XOR opB[0] XOR carryIn.
- R3: Each lookahead cell merges its two children as follows:
  - Group generate is highG OR (highP AND lowG).
  - Group propagate is highP AND lowP.
  - The low child receives the cell's carry-in unchanged.
  - The high child receives lowG OR (lowP AND cell carry-in).
- R4: When every bit propagates (opB equals the bitwise inverse of opA), the carry runs through the whole word:
  - With carryIn 1, the result is sum 0 and carryOut 1.
  - With carryIn 0, the result is sum all ones and carryOut 0.
- R5: carryOut equals rootG OR (rootP AND carryIn). In particular, a generate at the top bit alone (opA = opB = 0x80 at 8 bits, carryIn 0) gives sum 0 and carryOut 1.
- R6: For every opA, opB and carryIn, {carryOut, sum} equals opA + opB + carryIn as unsigned integers.
- R7: The outputs depend on the current inputs only. A new input value is reflected at sum and carryOut without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of opA + opB + carryIn |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The bench sweeps every operand pair with both carry-in values. This catches a cell that feeds its high child from the high pair instead of the low pair: such a design miscounts carries whenever a generate sits in a lower half. The all-propagate words, where one carry-in must travel the full width, expose a tree that drops the carry at some level and returns sum all ones with carryOut 0. A lone top-bit generate with no other carries exposes a carry-out taken from the top carry instead of the root group terms. A change of inputs between clock edges exposes any hidden state or latch.

// File: rtl/adderPkg.sv
package adderPkg;
  typedef struct packed {
    logic gen;
    logic prop;
  } gpPair;
endpackage

// File: rtl/bitTerms.sv
module bitTerms #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] bitG,
  output logic [WIDTH-1:0] bitP
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign bitG[i] = opA[i] & opB[i];
      assign bitP[i] = opA[i] ^ opB[i];
    end
  endgenerate

  // R1: a position cannot both generate and propagate
  always_comb begin
    a_r1_gp_exclusive: assert ((bitG & bitP) == '0)
      else $error("R1 generate and propagate overlap");
  end
endmodule

// File: rtl/lookaheadCell.sv
module lookaheadCell
  import adderPkg::*;
(
  input  gpPair hiIn,
  input  gpPair loIn,
  input  logic  cIn,
  output gpPair grpOut,
  output logic  cLo,
  output logic  cHi
);
  // R3: merge upward, split carry downward
  assign grpOut.gen  = hiIn.gen | (hiIn.prop & loIn.gen);
  assign grpOut.prop = hiIn.prop & loIn.prop;
  assign cLo         = cIn;
  assign cHi         = loIn.gen | (loIn.prop & cIn);
endmodule

// File: rtl/lookaheadTree.sv
module lookaheadTree
  import adderPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bitG,
  input  logic [WIDTH-1:0] bitP,
  input  logic             carryIn,
  output logic [WIDTH-1:0] bitCarry,
  output logic             groupG,
  output logic             groupP
);
  localparam int NODES = 2 * WIDTH;

  // heap numbering: node 1 is the root, node n has children 2n (low) and 2n+1 (high)
  gpPair nodeGp [NODES];
  logic  nodeC  [NODES];

  genvar i, n;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_leaf
      assign nodeGp[WIDTH+i] = '{gen: bitG[i], prop: bitP[i]};
      assign bitCarry[i]     = nodeC[WIDTH+i];
    end
    for (n = 1; n < WIDTH; n++) begin : g_node
      lookaheadCell u_cell (
        .hiIn  (nodeGp[2*n+1]),
        .loIn  (nodeGp[2*n]),
        .cIn   (nodeC[n]),
        .grpOut(nodeGp[n]),
        .cLo   (nodeC[2*n]),
        .cHi   (nodeC[2*n+1])
      );
    end
  endgenerate

  assign nodeC[0]  = 1'b0;
  assign nodeGp[0] = '{gen: 1'b0, prop: 1'b0};
  assign nodeC[1]  = carryIn;
  assign groupG    = nodeGp[1].gen;
  assign groupP    = nodeGp[1].prop;

  always_comb begin
    // R2: bit 0 always sees the external carry
    a_r2_lsb_carry: assert (bitCarry[0] == carryIn)
      else $error("R2 carry into bit 0 differs from carryIn");
    // R4: a fully propagating word hands carryIn to every bit
    a_r4_full_propagate: assert (!groupP || (bitCarry == {WIDTH{carryIn}}))
      else $error("R4 propagate chain broken");
  end
endmodule

// File: rtl/treeCarryAdder.sv
module treeCarryAdder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH-1:0] bitG;
  logic [WIDTH-1:0] bitP;
  logic [WIDTH-1:0] bitCarry;
  logic             groupG;
  logic             groupP;

  bitTerms #(.WIDTH(WIDTH)) u_terms (
    .opA (opA),
    .opB (opB),
    .bitG(bitG),
    .bitP(bitP)
  );

  lookaheadTree #(.WIDTH(WIDTH)) u_tree (
    .bitG    (bitG),
    .bitP    (bitP),
    .carryIn (carryIn),
    .bitCarry(bitCarry),
    .groupG  (groupG),
    .groupP  (groupP)
  );

  assign sum      = bitP ^ bitCarry;
  assign carryOut = groupG | (groupP & carryIn);

  always_comb begin
    // R6: arithmetic identity over the whole word
    a_r6_sum_identity: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("R6 sum mismatch");
    // R5: the root cannot both generate and propagate
    a_r5_root_exclusive: assert (!(groupG && groupP))
      else $error("R5 root group terms overlap");
  end
endmodule

// File: tb/treeCarryAdder_tb.sv
module treeCarryAdder_tb;
  localparam int WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic carryIn = 1'b0;
  logic [WIDTH-1:0] sum;
  logic carryOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  treeCarryAdder #(.WIDTH(WIDTH)) u_dut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sum(sum), .carryOut(carryOut)
  );

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s a=%0h b=%0h cin=%0d got=%0h expected=%0h",
               tag, opA, opB, carryIn, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(posedge clk);
    opA = WIDTH'(a);
    opB = WIDTH'(b);
    carryIn = c[0];
    @(negedge clk);
  endtask

  function automatic int model(input int a, input int b, input int c);
    return a + b + c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset idle", {carryOut, sum}, 0);

    // R1: disjoint bits only propagate, no carry anywhere
    apply(8'h0F, 8'hF0, 0);
    check("R1 propagate only", {carryOut, sum}, 9'h0FF);
    apply(8'h55, 8'h55, 0);
    check("R1 generate only", {carryOut, sum}, 9'h0AA);

    // R2: carry-in lands on bit 0
    apply(8'h00, 8'h00, 1);
    check("R2 lsb carry", {carryOut, sum}, 9'h001);

    // R3: low-half generate must reach the high half
    apply(8'h0F, 8'h01, 0);
    check("R3 low to high carry", {carryOut, sum}, 9'h010);
    apply(8'h38, 8'h08, 0);
    check("R3 cross-cell carry", {carryOut, sum}, 9'h040);

    // R4: all-propagate words
    apply(8'hFF, 8'h00, 1);
    check("R4 full chain cin1", {carryOut, sum}, 9'h100);
    apply(8'hA5, 8'h5A, 0);
    check("R4 full chain cin0", {carryOut, sum}, 9'h0FF);

    // R5: lone top generate
    apply(8'h80, 8'h80, 0);
    check("R5 top generate", {carryOut, sum}, 9'h100);
    apply(8'hFF, 8'hFF, 1);
    check("R5 all generate", {carryOut, sum}, 9'h1FF);

    // R7: change inputs between edges, no clock needed
    @(posedge clk);
    #(CLK_PERIOD/8);
    opA = 8'h12; opB = 8'h34; carryIn = 1'b0;
    #1;
    check("R7 first value", {carryOut, sum}, 9'h046);
    opA = 8'hF0; opB = 8'h20; carryIn = 1'b1;
    #1;
    check("R7 second value", {carryOut, sum}, 9'h111);

    // R6: exhaustive sweep against the behavioural model
    for (int a = 0; a < (1 << WIDTH); a++) begin
      for (int b = 0; b < (1 << WIDTH); b++) begin
        for (int c = 0; c < 2; c++) begin
          apply(a, b, c);
          check("R6 exhaustive", {carryOut, sum}, model(a, b, c));
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule